// File: doc/BRIEF.md
# Buffered Factory-Program Sequencer

This block is the device-side controller for a streaming bulk-programming mode of a NOR-style flash model. The host writes a setup code and then a confirm code, both addressed to one block. The confirm address gives the starting word inside that block. From then on, every host write that lands in the same block is treated as data, never as a command. The data fills a fixed write buffer one slot at a time, starting at slot zero.

When the last slot is written, the block copies the buffer into the simulated array. The copy goes to consecutive words that follow on from where the previous copy ended. A settle time, set by a parameter, follows the copy. During the copy and the settle time the buffer-busy flag stays set, and host writes are ignored. A write to any other block leaves the mode. Any words that are only partly buffered at that moment are dropped.

Errors are raised at the confirm write. The causes are a locked target block, a bad programming-voltage input, and a start address that is not aligned to the buffer size. While the mode is active, reads return the status register. Otherwise reads return array contents. The array cells model NOR programming: a cell can only move bits from 1 to 0.

Top module: `fbp_sequencer`

## Requirements
- R1: After reset, status is 0x80 (bit 7 ready set, all other bits clear) and every array word reads 0xFFFF.
- R2: A SETUP_CODE (default 0x00A5) write followed by a CONFIRM_CODE (default 0x00C3) write to the same block enters the mode when there is no error; status then reads 0x00.
- R3: At confirm, each error cause sets its own bit and the mode is not entered. A locked block sets bits 7, 4 and 1 (0x92). A low voltage input sets bits 7, 4 and 3 (0x98). A start offset that is not a multiple of BUF_WORDS sets bits 7 and 4 (0x90).
- R4: Programming starts only after the BUF_WORDS-th (512) in-block write. Status bit 0 rises on the edge of that write and stays set for exactly BUF_WORDS + COMMIT_DELAY cycles (520 by default).
- R5: Buffer slot i is programmed to block word start + n·BUF_WORDS + i, where n counts the buffers already committed since entry.
- R6: Programming ANDs the new word into the cell, so a 0xFFFF pad word leaves the cell unchanged.
- R7: Writes made while bit 0 is set are ignored, whatever their block or code. The mode stays active and no array word outside the committed range changes.
- R8: While bit 7 is clear, rd_data reads {8'h00, status}. While bit 7 is set, rd_data reads the array word at rd_addr.
- R9: During a fill, the data values 0x0070, SETUP_CODE and CONFIRM_CODE are stored as plain data.
- R10: A write to another block while the buffer is empty ends the mode: status returns to 0x80 and committed data is kept.
- R11: A write to another block during a partial fill aborts the mode with status 0x80. None of the partly buffered words reach the array.
- R12: A successful confirm clears error bits left over from an earlier failed confirm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W (11) | Host write word address (upper bits select the block) |
| wr_data | input | DATA_W (16) | Host write data or command code |
| rd_addr | input | ADDR_W (11) | Host read word address |
| rd_data | output | DATA_W (16) | Status while the mode is active, array word otherwise |
| status | output | 8 | Status register: bit 7 ready, bit 4 program error, bit 3 voltage error, bit 1 lock error, bit 0 buffer busy |
| block_lock | input | NUM_BLOCKS (2) | Per-block lock bits, sampled at confirm |
| vpp_ok | input | 1 | Programming voltage good, sampled at confirm |

## Verification
A fill counter that is off by one shows up at the status port within one write. Bit 0 then either rises a write early or fails to rise on the 512th write. A wrong destination pointer or wrong slot order stays hidden until the mode is left. It then appears as mismatched words when the block is read back through rd_data. A commit that ends early or late changes the measured busy window by at least one cycle. A fill state that accepts writes it should ignore corrupts the data that is read back after exit.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARMED,
      ST_FILL,
      ST_COMMIT,
      ST_SETTLE
   } fbp_state_e;

   localparam int SB_BUF_BUSY = 0;
   localparam int SB_LOCK_ERR = 1;
   localparam int SB_VPP_ERR  = 3;
   localparam int SB_PGM_ERR  = 4;
   localparam int SB_READY    = 7;

endpackage

// File: rtl/fbp_write_buffer.sv
`timescale 1ns/1ps
module fbp_write_buffer #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 512,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_word,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] slots [DEPTH];

   always_ff @(posedge clk) begin
      if (we) slots[wr_idx] <= wr_word;
   end

   assign rd_word = slots[rd_idx];

endmodule

// File: rtl/fbp_array_model.sv
`timescale 1ns/1ps
module fbp_array_model #(
   parameter int DATA_W      = 16,
   parameter int WORDS       = 2048,
   parameter bit AND_PROGRAM = 1'b1,
   localparam int AW         = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pgm_en,
   input  logic [AW-1:0]     pgm_addr,
   input  logic [DATA_W-1:0] pgm_word,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] cells [WORDS];
   logic [DATA_W-1:0] next_word;

   generate
      if (AND_PROGRAM) begin : g_nor_cells
         assign next_word = cells[pgm_addr] & pgm_word;
      end else begin : g_plain_cells
         assign next_word = pgm_word;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) cells[i] <= '1;
      end else if (pgm_en) begin
         cells[pgm_addr] <= next_word;
      end
   end

   assign rd_word = cells[rd_addr];

endmodule

// File: rtl/fbp_commit_timer.sv
`timescale 1ns/1ps
module fbp_commit_timer #(
   parameter int DELAY = 8,
   localparam int CW   = $clog2(DELAY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   logic [CW-1:0] ticks_q;

   assign done = run && (ticks_q == CW'(DELAY - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ticks_q <= '0;
      else if (!run || done)   ticks_q <= '0;
      else                     ticks_q <= ticks_q + 1'b1;
   end

endmodule

// File: rtl/fbp_sequencer.sv
`timescale 1ns/1ps
module fbp_sequencer
   import fbp_pkg::*;
#(
   parameter int DATA_W           = 16,
   parameter int BUF_WORDS        = 512,
   parameter int BLOCK_WORDS      = 1024,
   parameter int NUM_BLOCKS       = 2,
   parameter int COMMIT_DELAY     = 8,
   parameter int unsigned SETUP_CODE   = 'h00A5,
   parameter int unsigned CONFIRM_CODE = 'h00C3,
   parameter bit AND_PROGRAM      = 1'b1,
   localparam int ADDR_W          = $clog2(BLOCK_WORDS) + $clog2(NUM_BLOCKS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rd_data,
   output logic [7:0]            status,
   input  logic [NUM_BLOCKS-1:0] block_lock,
   input  logic                  vpp_ok
);

   localparam int BUF_AW = $clog2(BUF_WORDS);
   localparam int BLK_AW = $clog2(BLOCK_WORDS);
   localparam int SEL_W  = $clog2(NUM_BLOCKS);

   // elaboration-time parameter checks
   generate
      if (BUF_WORDS < 2 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_bad_buf
         $error("BUF_WORDS must be a power of two of at least 2");
      end
      if (BLOCK_WORDS < BUF_WORDS || (BLOCK_WORDS & (BLOCK_WORDS - 1)) != 0) begin : g_bad_blk
         $error("BLOCK_WORDS must be a power of two not below BUF_WORDS");
      end
      if (NUM_BLOCKS < 2 || (NUM_BLOCKS & (NUM_BLOCKS - 1)) != 0) begin : g_bad_nblk
         $error("NUM_BLOCKS must be a power of two of at least 2");
      end
      if (COMMIT_DELAY < 1) begin : g_bad_delay
         $error("COMMIT_DELAY must be at least 1");
      end
      if (DATA_W < 8) begin : g_bad_dw
         $error("DATA_W must hold the 8-bit status");
      end
   endgenerate

   fbp_state_e         st_q;
   logic [SEL_W-1:0]   blk_q;
   logic [BLK_AW-1:0]  dst_q;
   logic [BUF_AW-1:0]  fill_q;
   logic [BUF_AW-1:0]  cmt_q;
   logic               err_pgm_q, err_vpp_q, err_lock_q;

   logic [SEL_W-1:0]   wr_blk;
   logic               in_blk, confirm_hit;
   logic               bad_lock, bad_vpp, bad_align, bad_any;
   logic               buf_we, fill_last, cmt_last;
   logic               settle_run, settle_done;
   logic [DATA_W-1:0]  buf_rd, arr_rd;
   logic               pgm_en;
   logic [ADDR_W-1:0]  pgm_addr;
   logic               ready, buf_busy;

   assign wr_blk      = wr_addr[ADDR_W-1:BLK_AW];
   assign in_blk      = (wr_blk == blk_q);
   assign confirm_hit = wr_en && (st_q == ST_ARMED) &&
                        (wr_data == DATA_W'(CONFIRM_CODE)) && in_blk;
   assign bad_lock    = block_lock[wr_blk];
   assign bad_vpp     = !vpp_ok;
   assign bad_align   = |wr_addr[BUF_AW-1:0];
   assign bad_any     = bad_lock || bad_vpp || bad_align;
   assign buf_we      = wr_en && (st_q == ST_FILL) && in_blk;
   assign fill_last   = (fill_q == BUF_AW'(BUF_WORDS - 1));
   assign cmt_last    = (cmt_q  == BUF_AW'(BUF_WORDS - 1));
   assign settle_run  = (st_q == ST_SETTLE);
   assign pgm_en      = (st_q == ST_COMMIT);
   assign pgm_addr    = {blk_q, dst_q + BLK_AW'(cmt_q)};

   fbp_write_buffer #(
      .DATA_W (DATA_W),
      .DEPTH  (BUF_WORDS)
   ) u_buf (
      .clk     (clk),
      .we      (buf_we),
      .wr_idx  (fill_q),
      .wr_word (wr_data),
      .rd_idx  (cmt_q),
      .rd_word (buf_rd)
   );

   fbp_array_model #(
      .DATA_W      (DATA_W),
      .WORDS       (BLOCK_WORDS * NUM_BLOCKS),
      .AND_PROGRAM (AND_PROGRAM)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .pgm_en   (pgm_en),
      .pgm_addr (pgm_addr),
      .pgm_word (buf_rd),
      .rd_addr  (rd_addr),
      .rd_word  (arr_rd)
   );

   fbp_commit_timer #(
      .DELAY (COMMIT_DELAY)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (settle_run),
      .done  (settle_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         blk_q      <= '0;
         dst_q      <= '0;
         fill_q     <= '0;
         cmt_q      <= '0;
         err_pgm_q  <= 1'b0;
         err_vpp_q  <= 1'b0;
         err_lock_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (wr_en && wr_data == DATA_W'(SETUP_CODE)) begin
                  st_q  <= ST_ARMED;
                  blk_q <= wr_blk;
               end
            end
            ST_ARMED: begin
               if (confirm_hit) begin
                  err_lock_q <= bad_lock;
                  err_vpp_q  <= bad_vpp;
                  err_pgm_q  <= bad_any;
                  dst_q      <= wr_addr[BLK_AW-1:0];
                  fill_q     <= '0;
                  st_q       <= bad_any ? ST_IDLE : ST_FILL;
               end else if (wr_en) begin
                  st_q <= ST_IDLE;
               end
            end
            ST_FILL: begin
               if (wr_en && !in_blk) begin
                  st_q   <= ST_IDLE;
                  fill_q <= '0;
               end else if (buf_we) begin
                  fill_q <= fill_q + 1'b1;
                  if (fill_last) begin
                     st_q  <= ST_COMMIT;
                     cmt_q <= '0;
                  end
               end
            end
            ST_COMMIT: begin
               cmt_q <= cmt_q + 1'b1;
               if (cmt_last) st_q <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_done) begin
                  st_q  <= ST_FILL;
                  dst_q <= dst_q + BLK_AW'(BUF_WORDS);
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ready    = (st_q == ST_IDLE) || (st_q == ST_ARMED);
   assign buf_busy = (st_q == ST_COMMIT) || (st_q == ST_SETTLE);

   always_comb begin
      status              = '0;
      status[SB_READY]    = ready;
      status[SB_PGM_ERR]  = err_pgm_q;
      status[SB_VPP_ERR]  = err_vpp_q;
      status[SB_LOCK_ERR] = err_lock_q;
      status[SB_BUF_BUSY] = buf_busy;
   end

   assign rd_data = ready ? arr_rd : DATA_W'(status);

endmodule

// File: rtl/fbp_sequencer_chk.sv
`timescale 1ns/1ps
module fbp_sequencer_chk #(
   parameter int DATA_W       = 16,
   parameter int BUF_WORDS    = 512,
   parameter int COMMIT_DELAY = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        status,
   input logic [DATA_W-1:0] rd_data
);

   localparam int WINDOW = BUF_WORDS + COMMIT_DELAY;

   int busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         busy_run <= 0;
      else if (status[0]) busy_run <= busy_run + 1;
      else                busy_run <= 0;
   end

   assert_ready_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] |-> !status[0]);

   assert_busy_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> busy_run < WINDOW);

   assert_busy_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[0]) |-> busy_run == WINDOW);

   assert_cause_sets_pgm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status[1] || status[3]) |-> status[4]);

   assert_error_leaves_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      status[4] |-> status[7]);

   assert_commit_ignores_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (status[0] && wr_en) |=> !status[7]);

   assert_read_gives_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !status[7] |-> rd_data == DATA_W'(status));

endmodule

bind fbp_sequencer fbp_sequencer_chk #(
   .DATA_W       (DATA_W),
   .BUF_WORDS    (BUF_WORDS),
   .COMMIT_DELAY (COMMIT_DELAY)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .status  (status),
   .rd_data (rd_data)
);

// File: tb/tb_fbp_sequencer.sv
`timescale 1ns/1ps
module tb_fbp_sequencer;

   localparam int DW    = 16;
   localparam int BUF   = 512;
   localparam int BLK   = 1024;
   localparam int NBLK  = 2;
   localparam int DLY   = 8;
   localparam int AW    = 11;
   localparam logic [15:0] C_SETUP   = 16'h00A5;
   localparam logic [15:0] C_CONFIRM = 16'h00C3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic [AW-1:0]   rd_addr = '0;
   logic [DW-1:0]   rd_data;
   logic [7:0]      status;
   logic [NBLK-1:0] block_lock = '0;
   logic            vpp_ok = 1'b1;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   logic [15:0] model [BLK*NBLK];

   always #2 clk = ~clk;

   fbp_sequencer #(
      .DATA_W(DW), .BUF_WORDS(BUF), .BLOCK_WORDS(BLK), .NUM_BLOCKS(NBLK),
      .COMMIT_DELAY(DLY), .SETUP_CODE(32'(C_SETUP)), .CONFIRM_CODE(32'(C_CONFIRM)),
      .AND_PROGRAM(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .status(status),
      .block_lock(block_lock), .vpp_ok(vpp_ok)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic enter(input logic [AW-1:0] a);
      wr(a, C_SETUP);
      wr(a, C_CONFIRM);
   endtask

   // expected array update for one committed buffer
   function automatic logic [15:0] nor_pgm(input logic [15:0] old_w, input logic [15:0] new_w);
      return old_w & new_w;
   endfunction

   // writes a full buffer of data; pad_from: slot index from which 0xFFFF is sent
   task automatic fill(input int blk, input int dst, input int pad_from, input bit specials);
      logic [15:0] d;
      for (int i = 0; i < BUF; i++) begin
         d = (i >= pad_from) ? 16'hFFFF : 16'($urandom);
         if (specials && i == 3) d = 16'h0070;   // R9 status-read code is data
         if (specials && i == 4) d = C_SETUP;    // R9
         if (specials && i == 5) d = C_CONFIRM;  // R9
         if (i == BUF - 1)
            chk(status == 8'h00, "R4 no commit before buffer full", status, 8'h00);
         model[blk*BLK + dst + i] = nor_pgm(model[blk*BLK + dst + i], d);
         wr(AW'(blk*BLK + ($urandom % BLK)), d);
      end
   endtask

   task automatic wait_commit(output int n);
      n = 0;
      while (status[0]) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic cmp_block(input int blk, input string tag);
      int bad = 0;
      int first_act = 0, first_exp = 0;
      for (int i = 0; i < BLK; i++) begin
         rd_addr = AW'(blk*BLK + i);
         #0.5;
         if (rd_data !== model[blk*BLK + i]) begin
            if (bad == 0) begin first_act = rd_data; first_exp = model[blk*BLK + i]; end
            bad++;
         end
         @(negedge clk);
      end
      chk(bad == 0, tag, first_act, first_exp);
   endtask

   initial begin
      int n;
      void'($urandom(32'd4242));
      for (int i = 0; i < BLK*NBLK; i++) model[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk(status == 8'h80, "R1 reset status", status, 8'h80);
      rd_addr = AW'($urandom % (BLK*NBLK));
      #0.5;
      chk(rd_data == 16'hFFFF, "R1 erased array", rd_data, 16'hFFFF);
      @(negedge clk);

      // confirm errors
      block_lock = 2'b10;
      enter(AW'(BLK));
      chk(status == 8'h92, "R3 locked block", status, 8'h92);
      block_lock = 2'b00; vpp_ok = 1'b0;
      enter(AW'(0));
      chk(status == 8'h98, "R3 bad voltage", status, 8'h98);
      vpp_ok = 1'b1;
      enter(AW'(5));
      chk(status == 8'h90, "R3 misaligned start", status, 8'h90);

      // good entry clears stale errors
      enter(AW'(0));
      chk(status == 8'h00, "R2 R12 mode entered, errors cleared", status, 8'h00);
      #0.5;
      chk(rd_data == 16'h0000, "R8 read returns status", rd_data, 16'h0000);
      @(negedge clk);

      // first buffer with command codes inside, writes during commit
      fill(0, 0, BUF, 1'b1);
      n = 0;
      while (status[0]) begin
         n++;
         if (n == 2)      wr(AW'(BLK + 5), 16'h1234);  // R7 other block
         else if (n == 3) wr(AW'(7), C_SETUP);          // R7 command code
         else             @(negedge clk);
      end
      chk(n == BUF + DLY, "R4 busy window length", n, BUF + DLY);
      chk(status == 8'h00, "R7 mode kept after commit", status, 8'h00);

      // second buffer padded with 0xFFFF, lands after the first
      fill(0, BUF, 100, 1'b0);
      wait_commit(n);
      chk(n == BUF + DLY, "R4 second busy window", n, BUF + DLY);

      wr(AW'(BLK + 9), 16'hFFFF);
      chk(status == 8'h80, "R10 exit on block change", status, 8'h80);
      cmp_block(0, "R5 R6 R9 block contents after two buffers");
      cmp_block(1, "R7 other block untouched");

      // reprogram same region: cells AND together
      enter(AW'(0));
      fill(0, 0, BUF, 1'b0);
      wait_commit(n);
      wr(AW'(BLK), 16'hFFFF);
      cmp_block(0, "R6 AND programming");

      // partial fill aborted by block change
      enter(AW'(BUF));
      chk(status == 8'h00, "R2 aligned second-half entry", status, 8'h00);
      begin
         int k = 1 + ($urandom % (BUF - 1));
         for (int i = 0; i < k; i++) wr(AW'($urandom % BLK), 16'h0000);
      end
      wr(AW'(BLK + 3), 16'h5A5A);
      chk(status == 8'h80, "R11 abort status", status, 8'h80);
      cmp_block(0, "R11 partial words discarded");

      // immediate exit
      enter(AW'(BLK));
      wr(AW'(0), 16'hFFFF);
      chk(status == 8'h80, "R10 immediate exit", status, 8'h80);
      rd_addr = AW'(3);
      #0.5;
      chk(rd_data == model[3], "R8 read array when ready", rd_data, model[3]);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule